// File: doc/BRIEF.md
# Power-Fail Bus Initialize Controller

This block sits on the processor side of a backplane bus. It drives the active-low bus initialize line from two supply status inputs: DC-OK, which says the supply voltages are within limits, and POWER-OK, which gives early warning that input power is failing. At power-up, initialize is held asserted until DC-OK is seen. Once POWER-OK has been present and is then lost, the block treats the power-down as committed. It waits at least 3 ms, issues one initialize pulse of bounded width, and then raises a halt request. The halt request stays latched until DC-OK drops. After that the block is back in its power-up state with initialize asserted.

A second output, `crit_ok`, tells the rest of the chip when critical actions are allowed. It is true only while the block is in normal operation with POWER-OK held. Both status inputs are asynchronous and each passes through a two-flop synchronizer. All delays are set as times in microseconds and converted to clock cycles from a clock-frequency parameter. The minimum wait and the pulse width are clamped to their legal ranges.

Top module: `pwrfail_init_ctrl`

## Requirements
- R1: While `rst_n` is low, on the following clock edge `bus_init_n` is 0, `halt_req` is 0 and `crit_ok` is 0.
- R2: Each status input acts through two synchronizing flops. An input change driven between edges first affects the outputs after the third rising edge that follows, and not after the second.
- R3: In the power-up state, `bus_init_n` goes to 1 on the same edge that the synchronized DC-OK is first seen high. No added delay applies.
- R4: `crit_ok` is 1 only in normal operation, which is entered when synchronized POWER-OK is high after DC-OK. It goes to 0 on the third edge after POWER-OK drops. It stays 0 for the rest of a power-down sequence, even if POWER-OK returns.
- R5: After POWER-OK drops during normal operation, `bus_init_n` goes to 0 exactly 3 + WAIT_CYC edges later. WAIT_CYC = ceil(CLK_KHZ * max(WAIT_US, 3000) / 1000).
- R6: The power-fail initialize pulse keeps `bus_init_n` at 0 for exactly PULSE_CYC cycles. PULSE_CYC = floor(CLK_KHZ * clamp(PULSE_US, 8, 20) / 1000).
- R7: `halt_req` rises on the same edge on which `bus_init_n` returns to 1 at the end of the pulse.
- R8: `halt_req` stays 1 while DC-OK is high. On the third edge after DC-OK drops, `halt_req` goes to 0 and `bus_init_n` goes to 0.
- R9: If POWER-OK returns during the wait, the sequence still runs to completion with the timing of R5, R6 and R7.
- R10: If DC-OK drops during normal operation, `bus_init_n` goes to 0 and `crit_ok` goes to 0 on the third edge after the drop, and `halt_req` is never raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dc_ok_in | input | 1 | Asynchronous supply DC-OK status, high when voltages are good |
| pwr_ok_in | input | 1 | Asynchronous supply POWER-OK status, high when input power is good |
| bus_init_n | output | 1 | Active-low bus initialize |
| crit_ok | output | 1 | High while critical actions are permitted |
| halt_req | output | 1 | Latched halt request after the power-fail pulse |

## Verification
The bench runs three instances side by side: one with a nominal pulse, one with a pulse below the legal range and one with a pulse above it. The instance with the pulse above range also has a wait below the minimum. Because all three get the same stimulus, the exact edge counts from the POWER-OK drop show both the clamping and the cycle conversion. The power-down sequence is tried in three ways. In the first, POWER-OK simply drops. In the second, POWER-OK returns part-way through the wait, which tests the committed behaviour. In the third, DC-OK drops before POWER-OK does, which must give an initialize without a halt. Power-up release and the halt exit are checked one edge before and exactly at the edge where the synchronizer delay predicts them, which tests the synchronizer depth against a late or early response.

// File: rtl/pwrfail_pkg.sv
// Shared types and helpers for the power-fail bus initialize controller.
// Assumes: integer parameters in microseconds and kilohertz, all small enough for 32-bit math.
package pwrfail_pkg;

    // Sequencer states; PWRUP is the reset state
    typedef enum logic [2:0] {
        ST_PWRUP  = 3'd0,
        ST_RUN    = 3'd1,
        ST_ONLINE = 3'd2,
        ST_WAIT   = 3'd3,
        ST_PULSE  = 3'd4,
        ST_HALT   = 3'd5
    } pf_state_e;

    // Legal window for the power-fail pulse, microseconds
    localparam int PULSE_MIN_US = 8;
    localparam int PULSE_MAX_US = 20;
    // Shortest allowed wait after POWER-OK loss, microseconds
    localparam int WAIT_MIN_US  = 3000;

    // Restrict a value to [lo, hi]
    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // Larger of two values
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pf_sync2.sv
// Two-flop synchronizer bank for W independent asynchronous level inputs.
// Assumes: inputs are slow levels; a change is seen two edges after capture.
module pf_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one asynchronous bit, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_in[i];
                stab_q <= meta_q;
            end
        end

        assign q_out[i] = stab_q;
    end

endmodule

// File: rtl/pf_timer.sv
// Up-counter timing a sequencer phase: cleared on phase change, counts while
// enabled, flags the cycle in which the count equals the phase limit.
// Assumes: limit is stable for the whole phase and clr is pulsed on entry.
module pf_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Phase cycle count: restart on clear, advance while enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Final cycle of the phase
    assign done = en && (cnt_q == limit);

    // R5/R6: the count never runs past the active phase limit
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> (cnt_q <= limit));

endmodule

// File: rtl/pf_seq.sv
// Power-fail sequencer: power-up hold, normal operation, committed power-down
// (wait, initialize pulse, latched halt). Outputs decode the state register.
// Assumes: dc_ok and pwr_ok are already synchronized to clk.
module pf_seq
    import pwrfail_pkg::*;
#(
    parameter int WAIT_CYC  = 3000,
    parameter int PULSE_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dc_ok,
    input  logic pwr_ok,
    output logic bus_init_n,
    output logic crit_ok,
    output logic halt_req
);

    localparam int MAXC = max_int(WAIT_CYC, PULSE_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WAIT_LIM  = CW'(WAIT_CYC - 1);
    localparam logic [CW-1:0] PULSE_LIM = CW'(PULSE_CYC - 1);

    pf_state_e     st_q, st_nxt;
    logic          tmr_clr, tmr_en, tmr_done;
    logic [CW-1:0] tmr_lim;

    // Next-state selection; loss of DC-OK always returns to power-up
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_PWRUP:  if (dc_ok) st_nxt = ST_RUN;
            ST_RUN:    if (!dc_ok) st_nxt = ST_PWRUP;
                       else if (pwr_ok) st_nxt = ST_ONLINE;
            ST_ONLINE: if (!dc_ok) st_nxt = ST_PWRUP;
                       else if (!pwr_ok) st_nxt = ST_WAIT;
            ST_WAIT:   if (!dc_ok) st_nxt = ST_PWRUP;
                       else if (tmr_done) st_nxt = ST_PULSE;
            ST_PULSE:  if (!dc_ok) st_nxt = ST_PWRUP;
                       else if (tmr_done) st_nxt = ST_HALT;
            ST_HALT:   if (!dc_ok) st_nxt = ST_PWRUP;
            default:   st_nxt = ST_PWRUP;
        endcase
    end

    // State register, power-up state out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_PWRUP;
        else        st_q <= st_nxt;
    end

    // Timer control: restart on every transition, run in the timed phases
    always_comb begin
        tmr_clr = (st_nxt != st_q);
        tmr_en  = (st_q == ST_WAIT) || (st_q == ST_PULSE);
        tmr_lim = (st_q == ST_PULSE) ? PULSE_LIM : WAIT_LIM;
    end

    pf_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (tmr_en),
        .limit (tmr_lim),
        .done  (tmr_done)
    );

    // Output decode from the state register
    always_comb begin
        bus_init_n = !((st_q == ST_PWRUP) || (st_q == ST_PULSE));
        crit_ok    = (st_q == ST_ONLINE);
        halt_req   = (st_q == ST_HALT);
    end

    // R1: reset forces initialize on and both flags off
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!bus_init_n && !halt_req && !crit_ok));

    // R3: release in the same edge DC-OK is seen
    a_r3_release_on_dcok: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PWRUP && dc_ok) |=> bus_init_n);

    // R4: critical actions only with POWER-OK present the cycle before
    a_r4_crit_needs_pwrok: assert property (@(posedge clk) disable iff (!rst_n)
        crit_ok |-> $past(pwr_ok));

    // R6: with DC-OK held, initialize only drops out of the wait phase
    a_r6_pulse_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_init_n) && $past(dc_ok)) |-> ($past(st_q) == ST_WAIT));

    // R7: halt follows the pulse end immediately
    a_r7_halt_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PULSE && tmr_done && dc_ok) |=> (halt_req && bus_init_n));

    // R8: halt latched while DC-OK stays high
    a_r8_halt_held: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && dc_ok) |=> halt_req);

    // R8: DC-OK loss leaves halt for power-up
    a_r8_halt_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !dc_ok) |=> (!halt_req && !bus_init_n));

    // R9: the wait is never abandoned while DC-OK holds
    a_r9_committed: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && dc_ok) |=> (st_q == ST_WAIT || st_q == ST_PULSE));

endmodule

// File: rtl/pwrfail_init_ctrl.sv
// Top: converts time parameters to cycle counts (with legal clamping),
// synchronizes the two supply status inputs and runs the sequencer.
// Assumes: CLK_KHZ * max(WAIT_US,3000) fits in 32 bits; PULSE result >= 1 cycle.
module pwrfail_init_ctrl
    import pwrfail_pkg::*;
#(
    parameter int CLK_KHZ  = 50000,
    parameter int WAIT_US  = 3000,
    parameter int PULSE_US = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dc_ok_in,
    input  logic pwr_ok_in,
    output logic bus_init_n,
    output logic crit_ok,
    output logic halt_req
);

    localparam int WAIT_EFF_US  = max_int(WAIT_US, WAIT_MIN_US);
    localparam int PULSE_EFF_US = clamp_int(PULSE_US, PULSE_MIN_US, PULSE_MAX_US);
    localparam int WAIT_CYC     = (CLK_KHZ * WAIT_EFF_US + 999) / 1000;
    localparam int PULSE_CYC    = max_int((CLK_KHZ * PULSE_EFF_US) / 1000, 1);

    logic [1:0] raw_st, sync_st;

    assign raw_st = {pwr_ok_in, dc_ok_in};

    pf_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_st),
        .q_out (sync_st)
    );

    pf_seq #(
        .WAIT_CYC  (WAIT_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dc_ok      (sync_st[0]),
        .pwr_ok     (sync_st[1]),
        .bus_init_n (bus_init_n),
        .crit_ok    (crit_ok),
        .halt_req   (halt_req)
    );

endmodule

// File: tb/tb_pwrfail_init_ctrl.sv
module tb_pwrfail_init_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NDUT = 3;
    // 1 MHz clock in all instances: one cycle per microsecond
    localparam int WAIT_EXP [NDUT]  = '{3000, 3000, 3200};
    localparam int PULSE_EXP [NDUT] = '{12, 20, 8};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dc_ok = 1'b0;
    logic pwr_ok = 1'b0;
    logic [NDUT-1:0] binit_v, crit_v, halt_v;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrfail_init_ctrl #(.CLK_KHZ(1000), .WAIT_US(3000), .PULSE_US(12)) dut (
        .clk(clk), .rst_n(rst_n), .dc_ok_in(dc_ok), .pwr_ok_in(pwr_ok),
        .bus_init_n(binit_v[0]), .crit_ok(crit_v[0]), .halt_req(halt_v[0]));

    pwrfail_init_ctrl #(.CLK_KHZ(1000), .WAIT_US(100), .PULSE_US(30)) dut_hi (
        .clk(clk), .rst_n(rst_n), .dc_ok_in(dc_ok), .pwr_ok_in(pwr_ok),
        .bus_init_n(binit_v[1]), .crit_ok(crit_v[1]), .halt_req(halt_v[1]));

    pwrfail_init_ctrl #(.CLK_KHZ(1000), .WAIT_US(3200), .PULSE_US(3)) dut_lo (
        .clk(clk), .rst_n(rst_n), .dc_ok_in(dc_ok), .pwr_ok_in(pwr_ok),
        .bus_init_n(binit_v[2]), .crit_ok(crit_v[2]), .halt_req(halt_v[2]));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Power-up from the power-up state through to normal operation
    task automatic power_up();
        dc_ok = 1'b1;
        step(2);
        chk("R2 init still held after two edges", int'(binit_v), 0);
        step(1);
        chk("R3 init released at third edge", int'(binit_v), 7);
        chk("R4 crit off before POWER-OK", int'(crit_v), 0);
        pwr_ok = 1'b1;
        step(2);
        chk("R2 crit not yet on", int'(crit_v), 0);
        step(1);
        chk("R4 crit on with POWER-OK", int'(crit_v), 7);
    endtask

    // POWER-OK loss; optional return at step reassert_at
    task automatic power_down(input int reassert_at, input string tag);
        int fall_at [NDUT];
        int rise_at [NDUT];
        int halt_at [NDUT];
        int crit_fall;
        int crit_back;
        for (int d = 0; d < NDUT; d++) begin
            fall_at[d] = -1; rise_at[d] = -1; halt_at[d] = -1;
        end
        crit_fall = -1;
        crit_back = 0;
        pwr_ok = 1'b0;
        for (int i = 1; i <= 3400; i++) begin
            if (reassert_at != 0 && i == reassert_at) pwr_ok = 1'b1;
            step(1);
            for (int d = 0; d < NDUT; d++) begin
                if (fall_at[d] < 0 && !binit_v[d]) fall_at[d] = i;
                if (fall_at[d] >= 0 && rise_at[d] < 0 && binit_v[d]) rise_at[d] = i;
                if (halt_at[d] < 0 && halt_v[d]) halt_at[d] = i;
            end
            if (crit_fall < 0 && crit_v == '0) crit_fall = i;
            if (crit_fall >= 0 && crit_v != '0) crit_back = 1;
        end
        chk({"R4 crit fall edge ", tag}, crit_fall, 3);
        chk({"R4 crit stays off ", tag}, crit_back, 0);
        for (int d = 0; d < NDUT; d++) begin
            chk({"R5 pulse start ", tag}, fall_at[d], 3 + WAIT_EXP[d]);
            chk({"R6 pulse width ", tag}, rise_at[d] - fall_at[d], PULSE_EXP[d]);
            chk({"R7 halt at pulse end ", tag}, halt_at[d], rise_at[d]);
        end
        chk({"R8 halt held ", tag}, int'(halt_v), 7);
    endtask

    // DC-OK loss during the halt
    task automatic halt_exit();
        dc_ok = 1'b0;
        step(2);
        chk("R8 halt kept before sync delay", int'(halt_v), 7);
        step(1);
        chk("R8 halt cleared", int'(halt_v), 0);
        chk("R8 init asserted", int'(binit_v), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        step(3);
        chk("R1 reset init", int'(binit_v), 0);
        chk("R1 reset crit", int'(crit_v), 0);
        chk("R1 reset halt", int'(halt_v), 0);
        rst_n = 1'b1;
        step(2);

        // Plain power-down
        power_up();
        power_down(0, "plain");
        halt_exit();

        // POWER-OK returns mid-wait: committed (R9)
        power_up();
        power_down(100, "R9 reassert");
        chk("R9 halt reached despite POWER-OK", int'(halt_v), 7);
        pwr_ok = 1'b0;
        halt_exit();

        // DC-OK lost in normal operation (R10)
        power_up();
        begin
            int halts;
            halts = 0;
            dc_ok = 1'b0;
            step(2);
            chk("R10 init not yet", int'(binit_v), 7);
            step(1);
            chk("R10 init asserted", int'(binit_v), 0);
            chk("R10 crit off", int'(crit_v), 0);
            for (int i = 0; i < 3400; i++) begin
                step(1);
                if (halt_v != '0) halts++;
            end
            chk("R10 no halt", halts, 0);
            chk("R10 init still asserted", int'(binit_v), 0);
        end

        summary();
    end

endmodule